// File: doc/BRIEF.md
# Serial Flash Command Engine

This block issues short, software-defined commands to a serial NOR flash over a single data line in each direction. A host fills in a packed control word, an address word and a write-data word through a small register port, then sets the execute bit. The engine lowers chip-select and shifts out the opcode. If the control word enables them, it then shifts out the address bytes and the write bytes, and shifts in the read bytes. Finally it releases chip-select and clears its in-progress flag.

The host polls the in-progress flag in the control register. Once it is clear, the host collects up to eight returned bytes from two 32-bit read-data registers, filled in arrival order from the least significant byte upward. The serial clock comes from an internal divider and idles low. Outgoing data changes on falling edges and incoming data is captured on rising edges.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, in-progress reads 0, chip-select is high, the serial clock is low, and the control, lower read-data and upper read-data registers read zero.
- R2: Register index 0 is the control word: opcode in [31:24], read enable at 23, read count minus one in [22:20], address enable at 19, address count minus one in [17:16], write enable at 15, write count minus one in [14:12]. Writing 1 to bit 0 starts a command. Bit 1 reads 1 while a command runs. Bits 0, 18 and [11:2] read 0. Indices 1 to 4 are the address, write-data, lower read-data and upper read-data registers.
- R3: A frame is the opcode, then the address bytes (when enabled), then the write bytes (when enabled), then the read bytes (when enabled). Every byte is sent most significant bit first. The address phase sends the low (count) bytes of the address register, highest of those bytes first.
- R4: Write bytes come from the write-data register, least significant byte first. A write count field of 4 to 7 sends 4 bytes.
- R5: Received byte k (k = 0 upward) is stored at bits [8k+7:8k] of the 64-bit value {upper, lower}. Both read-data registers are cleared when a command starts, so unreceived bytes read 0.
- R6: Chip-select stays low for exactly one continuous frame. The serial clock is low whenever chip-select is high. Outgoing data changes only on falling clock edges. Chip-select rises one system cycle before in-progress clears.
- R7: A control-register write while a command runs is ignored. It neither changes the frame nor the stored control fields.
- R8: Each serial clock level lasts HALF_DIV system cycles. A command of N frame bits keeps in-progress high for (2N+1)*HALF_DIV+1 cycles, counted from the cycle after the execute write.
- R9: A command with no phase enabled sends only the 8 opcode bits.
- R10: A control write with bit 0 clear stores the fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| flash_sclk | output | 1 | Serial clock to the flash |
| flash_cs_n | output | 1 | Active-low chip-select |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The execute write takes effect at the clock edge that samples it. Chip-select falls at that edge, and in-progress drops exactly (2N+1)*HALF_DIV+1 cycles later, with chip-select already high in the last of those cycles. The bench drives inputs and samples every output on the falling system clock edge. It counts busy cycles from the first sample after the execute write, so the count can be compared exactly against that formula. Frame bits are captured by a flash model on rising serial clock edges. Read-data registers are read only once in-progress is observed low, because the last byte is stored on the final falling serial edge.

// File: rtl/flash_cmd_pkg.sv
// Shared types and field positions for the serial flash command engine.
// Assumes a 32-bit host register port and a single-lane flash interface.
package flash_cmd_pkg;

    // Register indices on the host port
    localparam int REG_IDX_W  = 3;
    localparam logic [REG_IDX_W-1:0] RI_CTRL  = 3'd0;
    localparam logic [REG_IDX_W-1:0] RI_ADDR  = 3'd1;
    localparam logic [REG_IDX_W-1:0] RI_WDATA = 3'd2;
    localparam logic [REG_IDX_W-1:0] RI_RD_LO = 3'd3;
    localparam logic [REG_IDX_W-1:0] RI_RD_HI = 3'd4;

    // Control-word bit positions (host software decodes these)
    localparam int BIT_GO      = 0;
    localparam int BIT_BUSY    = 1;
    localparam int BIT_WR_EN   = 15;
    localparam int BIT_ADDR_EN = 19;
    localparam int BIT_RD_EN   = 23;

    localparam int WORD_W    = 32;
    localparam int RX_BYTES  = 8;
    localparam int RX_W      = RX_BYTES * 8;
    localparam int TX_MAXB   = 4;

    // Decoded command fields
    typedef struct packed {
        logic [7:0] opcode;
        logic       rd_en;
        logic [2:0] rd_cnt;
        logic       addr_en;
        logic [1:0] addr_cnt;
        logic       wr_en;
        logic [2:0] wr_cnt;
    } cmd_cfg_t;

    // Frame phases in their fixed order
    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADDR = 2'd1,
        PH_WR   = 2'd2,
        PH_RD   = 2'd3
    } phase_t;

    // Pull the command fields out of a control word
    function automatic cmd_cfg_t decode_ctrl(input logic [WORD_W-1:0] w);
        cmd_cfg_t c;
        c.opcode   = w[31:24];
        c.rd_en    = w[BIT_RD_EN];
        c.rd_cnt   = w[22:20];
        c.addr_en  = w[BIT_ADDR_EN];
        c.addr_cnt = w[17:16];
        c.wr_en    = w[BIT_WR_EN];
        c.wr_cnt   = w[14:12];
        return c;
    endfunction

    // Rebuild the readable control word
    function automatic logic [WORD_W-1:0] encode_ctrl(input cmd_cfg_t c, input logic busy);
        return {c.opcode, c.rd_en, c.rd_cnt, c.addr_en, 1'b0, c.addr_cnt,
                c.wr_en, c.wr_cnt, 10'd0, busy, 1'b0};
    endfunction

endpackage

// File: rtl/flash_cmd_regs.sv
// Host-side register file: holds the control fields, address and write data.
// Produces a one-cycle start request when the go bit is written while idle.
// Assumes the sequencer latches everything it needs at start.
module flash_cmd_regs
    import flash_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 busy,
    output cmd_cfg_t             ctrl_q,
    output logic [WORD_W-1:0]    addr_q,
    output logic [WORD_W-1:0]    wdat_q,
    output logic                 start,
    output cmd_cfg_t             start_cfg
);

    logic ctrl_hit;

    // Decode a control write that is allowed to land
    always_comb begin
        ctrl_hit  = wr_en && (idx == RI_CTRL) && !busy;
        start     = ctrl_hit && wdata[BIT_GO];
        start_cfg = decode_ctrl(wdata);
    end

    // Store host-written registers; control writes are dropped while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            addr_q <= '0;
            wdat_q <= '0;
        end else begin
            if (ctrl_hit)
                ctrl_q <= decode_ctrl(wdata);
            if (wr_en && idx == RI_ADDR)
                addr_q <= wdata;
            if (wr_en && idx == RI_WDATA)
                wdat_q <= wdata;
        end
    end

endmodule

// File: rtl/flash_cmd_clkdiv.sv
// Serial clock divider: emits a tick every HALF_DIV cycles while run is high.
// Each tick marks one serial clock half period. clr restarts the count.
module flash_cmd_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    generate
        if (HALF_DIV == 1) begin : g_full_rate
            // Every cycle is a half period
            always_comb tick = run;
        end else begin : g_divided
            logic [CW-1:0] cnt;
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

            // Half-period tick generation
            always_comb tick = run && (cnt == LAST);

            // Count system cycles within a half period
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    cnt <= '0;
                else if (run)
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/flash_cmd_seq.sv
// Phase sequencer and shift registers for one flash command frame.
// Order: opcode, address, write bytes, read bytes; each byte MSB first.
// Data out changes on falling serial edges, data in is taken on rising edges.
// Assumes start only arrives while idle and tick comes from the divider.
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_cfg_t          start_cfg,
    input  logic [WORD_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic [RX_W-1:0]   rx_data,
    output cmd_cfg_t          cfg_q
);

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SHIFT   = 2'd1,
        S_RELEASE = 2'd2,
        S_END     = 2'd3
    } state_t;

    state_t            state;
    phase_t            phase;
    logic [2:0]        bit_idx;
    logic [2:0]        byte_idx;
    logic [2:0]        byte_last;
    logic [7:0]        tx_sr;
    logic [7:0]        rx_sr;
    logic [WORD_W-1:0] addr_l;
    logic [WORD_W-1:0] wdat_l;
    logic              nxt_valid;
    phase_t            nxt_phase;

    // Last byte index of a phase
    function automatic logic [2:0] last_idx(input phase_t p, input cmd_cfg_t c);
        case (p)
            PH_ADDR: return {1'b0, c.addr_cnt};
            PH_WR:   return (c.wr_cnt > 3'd3) ? 3'd3 : c.wr_cnt;
            PH_RD:   return c.rd_cnt;
            default: return 3'd0;
        endcase
    endfunction

    // Byte to send for a phase and byte index
    function automatic logic [7:0] tx_byte(input phase_t p, input logic [2:0] i,
                                           input cmd_cfg_t c,
                                           input logic [WORD_W-1:0] a,
                                           input logic [WORD_W-1:0] w);
        logic [1:0] pos;
        pos = c.addr_cnt - i[1:0];
        case (p)
            PH_OPC:  return c.opcode;
            PH_ADDR: return a[{pos, 3'b000} +: 8];
            PH_WR:   return w[{i[1:0], 3'b000} +: 8];
            default: return 8'h00;
        endcase
    endfunction

    // Choose the phase that follows the current one
    always_comb begin
        nxt_valid = 1'b0;
        nxt_phase = PH_RD;
        case (phase)
            PH_OPC: begin
                if (cfg_q.addr_en)    begin nxt_valid = 1'b1; nxt_phase = PH_ADDR; end
                else if (cfg_q.wr_en) begin nxt_valid = 1'b1; nxt_phase = PH_WR;   end
                else if (cfg_q.rd_en) begin nxt_valid = 1'b1; nxt_phase = PH_RD;   end
            end
            PH_ADDR: begin
                if (cfg_q.wr_en)      begin nxt_valid = 1'b1; nxt_phase = PH_WR;   end
                else if (cfg_q.rd_en) begin nxt_valid = 1'b1; nxt_phase = PH_RD;   end
            end
            PH_WR: begin
                if (cfg_q.rd_en)      begin nxt_valid = 1'b1; nxt_phase = PH_RD;   end
            end
            default: ;
        endcase
    end

    // Status and serial data out
    always_comb begin
        busy = (state != S_IDLE);
        mosi = tx_sr[7];
    end

    // Frame sequencing, shifting and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= PH_OPC;
            bit_idx   <= 3'd7;
            byte_idx  <= 3'd0;
            byte_last <= 3'd0;
            tx_sr     <= 8'h00;
            rx_sr     <= 8'h00;
            rx_data   <= '0;
            cfg_q     <= '0;
            addr_l    <= '0;
            wdat_l    <= '0;
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        cfg_q     <= start_cfg;
                        addr_l    <= cmd_addr;
                        wdat_l    <= cmd_wdata;
                        phase     <= PH_OPC;
                        bit_idx   <= 3'd7;
                        byte_idx  <= 3'd0;
                        byte_last <= 3'd0;
                        tx_sr     <= start_cfg.opcode;
                        rx_data   <= '0;
                        cs_n      <= 1'b0;
                        sclk      <= 1'b0;
                        state     <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk <= 1'b1;
                            if (phase == PH_RD)
                                rx_sr <= {rx_sr[6:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (phase == PH_RD && bit_idx == 3'd0)
                                rx_data[{byte_idx, 3'b000} +: 8] <= rx_sr;
                            if (bit_idx != 3'd0) begin
                                bit_idx <= bit_idx - 3'd1;
                                tx_sr   <= {tx_sr[6:0], 1'b0};
                            end else if (byte_idx != byte_last) begin
                                byte_idx <= byte_idx + 3'd1;
                                bit_idx  <= 3'd7;
                                tx_sr    <= tx_byte(phase, byte_idx + 3'd1, cfg_q, addr_l, wdat_l);
                            end else if (nxt_valid) begin
                                phase     <= nxt_phase;
                                byte_idx  <= 3'd0;
                                bit_idx   <= 3'd7;
                                byte_last <= last_idx(nxt_phase, cfg_q);
                                tx_sr     <= tx_byte(nxt_phase, 3'd0, cfg_q, addr_l, wdat_l);
                            end else begin
                                tx_sr <= 8'h00;
                                state <= S_RELEASE;
                            end
                        end
                    end
                end
                S_RELEASE: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        state <= S_END;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_engine.sv
// Top of the register-triggered serial flash command engine.
// Connects the host register file, clock divider and frame sequencer,
// and multiplexes the host read-back word.
module flash_cmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        flash_sclk,
    output logic        flash_cs_n,
    output logic        flash_mosi,
    input  logic        flash_miso
);

    cmd_cfg_t          ctrl_q;
    cmd_cfg_t          start_cfg;
    cmd_cfg_t          seq_cfg;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdat_q;
    logic              start;
    logic              busy;
    logic              tick;
    logic [RX_W-1:0]   rx_data;

    flash_cmd_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .idx       (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .ctrl_q    (ctrl_q),
        .addr_q    (addr_q),
        .wdat_q    (wdat_q),
        .start     (start),
        .start_cfg (start_cfg)
    );

    flash_cmd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .run   (busy),
        .tick  (tick)
    );

    flash_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_cfg (start_cfg),
        .cmd_addr  (addr_q),
        .cmd_wdata (wdat_q),
        .tick      (tick),
        .miso      (flash_miso),
        .busy      (busy),
        .cs_n      (flash_cs_n),
        .sclk      (flash_sclk),
        .mosi      (flash_mosi),
        .rx_data   (rx_data),
        .cfg_q     (seq_cfg)
    );

    // Host read-back multiplexer
    always_comb begin
        case (reg_addr)
            RI_CTRL:  reg_rdata = encode_ctrl(ctrl_q, busy);
            RI_ADDR:  reg_rdata = addr_q;
            RI_WDATA: reg_rdata = wdat_q;
            RI_RD_LO: reg_rdata = rx_data[31:0];
            RI_RD_HI: reg_rdata = rx_data[63:32];
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_engine_chk.sv
// Protocol checker for the flash command engine, bound to the top module.
// Assumes synchronous active-low reset on rst_n.
module flash_cmd_engine_chk
    import flash_cmd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input logic     clk,
    input logic     rst_n,
    input logic     busy,
    input logic     cs_n,
    input logic     sclk,
    input logic     mosi,
    input cmd_cfg_t cfg_q
);

    logic        sclk_d;
    logic [15:0] gap;

    // Track cycles since the last serial clock change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            gap    <= '0;
        end else begin
            sclk_d <= sclk;
            if (sclk != sclk_d)
                gap <= 16'd1;
            else if (gap != 16'hFFFF)
                gap <= gap + 16'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && cs_n && !sclk));

    // R6
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    // R6
    clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R6
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cs_n));

    // R6
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && (mosi != $past(mosi))) |-> (!sclk && $past(sclk)));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_q));

    // R8
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_d && !sclk) |-> (gap == 16'(HALF_DIV)));

endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .cs_n  (flash_cs_n),
    .sclk  (flash_sclk),
    .mosi  (flash_mosi),
    .cfg_q (seq_cfg)
);

// File: tb/flash_cmd_engine_test.sv
// Self-checking bench: vector table of commands, then directed cases.
module flash_cmd_engine_test;

    localparam int H = 3;
    localparam logic [2:0] A_CTRL = 3'd0, A_ADDR = 3'd1, A_WD = 3'd2,
                           A_LO = 3'd3, A_HI = 3'd4;

    // {control word, address, write data, response seed}
    localparam int NV = 7;
    localparam logic [103:0] VEC [0:NV-1] = '{
        {32'h0600_0001, 32'h0000_0000, 32'h0000_0000, 8'h11},  // opcode only
        {32'h9FA0_0001, 32'h0000_0000, 32'h0000_0000, 8'h3C},  // read 3
        {32'hD80A_0001, 32'h0012_3456, 32'h0000_0000, 8'h00},  // addr 3
        {32'h0100_9001, 32'h0000_0000, 32'hCCBB_AA55, 8'h00},  // write 2
        {32'h0BFB_B001, 32'hDEAD_BEEF, 32'h4433_2211, 8'h5A},  // all, read 8
        {32'h03C8_0001, 32'h0000_00A7, 32'h0000_0000, 8'h81},  // addr 1, read 5
        {32'h0200_E001, 32'h0000_0000, 32'h8877_6655, 8'h00}   // write cnt 6 -> 4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flash_sclk, flash_cs_n, flash_mosi;
    logic        flash_miso = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // flash model state
    logic [7:0] seed_cur = 8'h00;
    logic       cap [0:255];
    int         nbits = 0;
    int         frames = 0;

    always #5 clk = ~clk;

    flash_cmd_engine #(.HALF_DIV(H)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flash_sclk(flash_sclk),
        .flash_cs_n(flash_cs_n), .flash_mosi(flash_mosi), .flash_miso(flash_miso)
    );

    function automatic logic [7:0] resp(input logic [7:0] s, input int j);
        return 8'hA5 ^ 8'(j * 29) ^ s;
    endfunction

    function automatic logic mbit(input int p);
        logic [7:0] b;
        b = resp(seed_cur, p / 8);
        return b[7 - (p % 8)];
    endfunction

    // flash model: frame start, capture on rise, drive on fall
    always @(negedge flash_cs_n) begin
        nbits = 0;
        frames = frames + 1;
        flash_miso = mbit(0);
    end
    always @(posedge flash_sclk) if (!flash_cs_n) begin
        if (nbits < 256) cap[nbits] = flash_mosi;
        nbits = nbits + 1;
    end
    always @(negedge flash_sclk) if (!flash_cs_n) flash_miso = mbit(nbits);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_addr = A_CTRL;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata; reg_addr = A_CTRL;
    endtask

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = cap[8 * k + i];
        return b;
    endfunction

    task automatic run_vec(input logic [103:0] v);
        logic [31:0] ctl, adr, wd, r;
        logic [7:0]  exp [0:16];
        logic [63:0] exp_rd;
        int na, nw, nr, nb, cnt, csr, f0, bad;
        ctl = v[103:72]; adr = v[71:40]; wd = v[39:8]; seed_cur = v[7:0];
        na = ctl[19] ? int'(ctl[17:16]) + 1 : 0;
        nw = ctl[15] ? ((int'(ctl[14:12]) + 1 > 4) ? 4 : int'(ctl[14:12]) + 1) : 0;
        nr = ctl[23] ? int'(ctl[22:20]) + 1 : 0;
        nb = 1 + na + nw + nr;
        exp[0] = ctl[31:24];
        for (int b = 0; b < na; b++) exp[1 + b] = adr[8 * (na - 1 - b) +: 8];
        for (int b = 0; b < nw; b++) exp[1 + na + b] = wd[8 * b +: 8];
        for (int b = 0; b < nr; b++) exp[1 + na + nw + b] = 8'h00;
        exp_rd = '0;
        for (int b = 0; b < nr; b++) exp_rd[8 * b +: 8] = resp(seed_cur, 1 + na + nw + b);
        f0 = frames;
        wr(A_ADDR, adr);
        wr(A_WD, wd);
        wr(A_CTRL, ctl);
        cnt = 0; csr = -1;
        while (cnt < 100000) begin
            #1;
            if (!reg_rdata[1]) break;
            if (flash_cs_n && csr < 0) csr = cnt;
            cnt++;
            @(negedge clk);
        end
        check("R8 busy cycles", 64'(cnt), 64'((2 * 8 * nb + 1) * H + 1));
        check("R6 cs rises one cycle before busy clears", 64'(csr), 64'(cnt - 1));
        check("R6 single frame", 64'(frames - f0), 64'd1);
        check("R3 frame bit count", 64'(nbits), 64'(8 * (1 + na + nw + nr)));
        bad = 0;
        for (int k = 0; k < 1 + na + nw; k++)
            if (cap_byte(k) !== exp[k]) begin
                if (bad == 0) check(k > na ? "R4 write byte" : "R3 frame byte",
                                    64'(cap_byte(k)), 64'(exp[k]));
                bad++;
            end
        if (bad == 0) check("R3 R4 frame bytes", 64'(0), 64'(0));
        rd(A_LO, r); check("R5 read lower", 64'(r), exp_rd[31:0]);
        rd(A_HI, r); check("R5 read upper", 64'(r), exp_rd[63:32]);
        rd(A_CTRL, r); check("R2 control readback", 64'(r), 64'(ctl & 32'hFFFB_F000));
    endtask

    initial begin
        logic [31:0] r;
        int f0, cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n", 64'(flash_cs_n), 64'd1);
        check("R1 sclk", 64'(flash_sclk), 64'd0);
        rd(A_CTRL, r); check("R1 control/busy", 64'(r), 64'd0);
        rd(A_LO, r); check("R1 read lower", 64'(r), 64'd0);
        rd(A_HI, r); check("R1 read upper", 64'(r), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);   // R9 is VEC[0]

        // R10: fields stored, no frame started
        f0 = frames;
        wr(A_CTRL, 32'hA5B3_5000);
        repeat (30) @(negedge clk);
        rd(A_CTRL, r); check("R10 stored fields", 64'(r), 64'hA5B3_5000);
        check("R10 no frame", 64'(frames - f0), 64'd0);
        check("R10 cs_n idle", 64'(flash_cs_n), 64'd1);

        // R7: control write during a command is ignored
        seed_cur = 8'h22;
        f0 = frames;
        wr(A_CTRL, 32'h9F90_0001);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 32'h0600_0001);
        cnt = 0;
        while (cnt < 100000) begin
            #1; if (!reg_rdata[1]) break;
            cnt++; @(negedge clk);
        end
        check("R7 frame length unchanged", 64'(nbits), 64'd24);
        check("R7 opcode unchanged", 64'(cap_byte(0)), 64'h9F);
        check("R7 one frame", 64'(frames - f0), 64'd1);
        rd(A_CTRL, r); check("R7 control unchanged", 64'(r), 64'h9F90_0000);
        rd(A_LO, r); check("R7 read data", 64'(r), 64'({resp(8'h22, 2), resp(8'h22, 1)}));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule